// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter behind an 8-bit register port. It counts either a fixed tick of one per four system clocks or rising edges seen on an external count input. Its count input passes a selectable divide-by-1/2/4/8 stage first. Software sets it up through a control register. It reads and writes the count as two bytes, and a holding register for the upper byte keeps both 16-bit transfers coherent. A rollover sets a sticky flag that drives the interrupt output. A clear pulse from a neighbouring compare unit forces the count back to zero.

The external input is always sampled in the system clock domain. In the synchronized setting it crosses two flops before edge detection. In the bypass setting only one flop stands in front of the edge detector, so a count lands one clock sooner. Every count then still changes on a system clock edge, and software reads need no snapshot.

Top module: `tmr16_prescaled`

## Requirements
- R1: After reset the count, the control register, the high-byte holding register and the overflow flag are all zero, and `ovf_flag_o` is low.
- R2: While the run bit (control bit 0) is 0, the count holds its value, except for a clear pulse or a low-byte write.
- R3: With the source bit (control bit 1) at 0, the count input gets one tick every fourth system clock. Ticks fall on the 4th, 8th, 12th ... rising edge after reset is released.
- R4: The divide field (control bits 4:3) lets through one count per 1, 2, 4 or 8 input ticks for the codes 0, 1, 2, 3. A low-byte write restarts the divide stage.
- R5: With the source bit at 1 and the bypass bit (control bit 2) at 0, a rising edge on `ext_clk_i` that is first sampled at clock edge k increments the count at edge k+2.
- R6: With the source bit at 1 and the bypass bit at 1, the same edge increments the count at edge k+1.
- R7: An increment from 0xFFFF gives 0x0000 and sets the overflow flag. The flag reads as control bit 7 and drives `ovf_flag_o` from the next clock.
- R8: A control write with data bit 7 at 0 clears the flag. A control write with bit 7 at 1 leaves the flag alone. A rollover in the same cycle as a clearing write leaves the flag set.
- R9: Address 2 reads and writes only the holding register. A read of address 1 returns the low count byte and copies the current high count byte into the holding register.
- R10: A write to address 1 loads the count with {holding register, write data} in one step.
- R11: A high `trig_clr_i` at a clock edge makes the count zero. This wins over a same-cycle increment and over a same-cycle low-byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External count input, may be asynchronous |
| trig_clr_i | input | 1 | Clear pulse from the compare unit |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (side effect on address 1) |
| bus_addr_i | input | 2 | Register select: 0 control, 1 low byte, 2 high-byte holding |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register |
| ovf_flag_o | output | 1 | Sticky overflow interrupt flag |

## Verification
Three pairs of events can land on the same clock edge: a rollover and a flag-clearing control write, an increment and a clear pulse, and a clear pulse and a low-byte load. The bench provokes each pair with the external input in bypass mode. It raises the pin, then issues the write or the pulse exactly one clock later, so both land on the increment edge. It then judges the outcome from the flag pin and the low byte. A behavioural model, compared on every clock, settles all other cases, including counting from a free-running external clock at an unrelated rate.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;
    localparam int PS_W   = 2;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HBUF = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Packed so that run is bit 0 and the divide code is bits 4:3
    typedef struct packed {
        logic [PS_W-1:0] div_code;
        logic            bypass_sync;
        logic            ext_src;
        logic            run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr16_tick_src.sv
`timescale 1ns/1ps
module tmr16_tick_src #(
    parameter int INT_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    input  logic ext_sel_i,
    input  logic bypass_i,
    output logic tick_o
);
    localparam int DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
    localparam int SH_W  = SYNC_STAGES + 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SH_W-1:0]  sh;
    } src_st_t;

    src_st_t st_d, st_q;
    logic    int_tick;
    logic    edge_sync;
    logic    edge_fast;

    always_comb begin
        st_d     = st_q;
        st_d.sh  = {st_q.sh[SH_W-2:0], ext_i};
        st_d.div = (st_q.div == DIV_LAST) ? '0 : st_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (INT_DIV == 1) begin : g_no_div
            assign int_tick = 1'b1;
        end else begin : g_div
            assign int_tick = (st_q.div == DIV_LAST);
        end
    endgenerate

    // sh[0] is the newest sample; the synchronized edge looks deeper
    assign edge_sync = st_q.sh[SYNC_STAGES-1] & ~st_q.sh[SYNC_STAGES];
    assign edge_fast = st_q.sh[0] & ~st_q.sh[1];

    always_comb begin
        if (!ext_sel_i) begin
            tick_o = int_tick;
        end else if (bypass_i) begin
            tick_o = edge_fast;
        end else begin
            tick_o = edge_sync;
        end
    end
endmodule

// File: rtl/tmr16_prescale.sv
`timescale 1ns/1ps
module tmr16_prescale #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            run_i,
    input  logic            clr_i,
    input  logic [PS_W-1:0] sel_i,
    output logic            inc_o
);
    localparam int MAX_SHIFT = (1 << PS_W) - 1;
    localparam int PRE_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = PRE_W'((1 << sel_i) - 1);
        pre_d = pre_q;
        inc_o = 1'b0;
        if (clr_i) begin
            pre_d = '0;
        end else if (run_i && tick_i) begin
            // >= covers a divide code lowered mid-count
            if (pre_q >= limit) begin
                pre_d = '0;
                inc_o = 1'b1;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/tmr16_prescaled.sv
`timescale 1ns/1ps
module tmr16_prescaled
    import tmr16_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int INT_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_i,
    input  logic              trig_clr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              ovf_flag_o
);
    localparam int BUS_W = CNT_W / 2;
    localparam int PAD_W = BUS_W - CTRL_W - 1;
    localparam int FLAG_BIT = BUS_W - 1;

    typedef struct packed {
        ctrl_t              ctrl;
        logic               ovf;
        logic [CNT_W-1:0]   cnt;
        logic [BUS_W-1:0]   hbuf;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    logic wr_ctrl, wr_lo, wr_hbuf, rd_lo;
    logic tick, inc, roll;
    logic [CNT_W:0] cnt_sum;

    // Observation points for the bound checker
    logic [CNT_W-1:0] cnt_now;
    logic [BUS_W-1:0] hbuf_now;
    logic             run_now;

    assign wr_ctrl = bus_wr_i && (bus_addr_i == SEL_CTRL);
    assign wr_lo   = bus_wr_i && (bus_addr_i == SEL_LO);
    assign wr_hbuf = bus_wr_i && (bus_addr_i == SEL_HBUF);
    assign rd_lo   = bus_rd_i && (bus_addr_i == SEL_LO);

    tmr16_tick_src #(
        .INT_DIV     (INT_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_i     (ext_clk_i),
        .ext_sel_i (st_q.ctrl.ext_src),
        .bypass_i  (st_q.ctrl.bypass_sync),
        .tick_o    (tick)
    );

    tmr16_prescale #(
        .PS_W (PS_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .run_i  (st_q.ctrl.run),
        .clr_i  (wr_lo),
        .sel_i  (st_q.ctrl.div_code),
        .inc_o  (inc)
    );

    assign cnt_sum = {1'b0, st_q.cnt} + 1'b1;

    always_comb begin
        st_d = st_q;
        roll = 1'b0;

        if (wr_ctrl) begin
            st_d.ctrl = ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
        end

        // Clear pulse, then load, then increment
        if (trig_clr_i) begin
            st_d.cnt = '0;
        end else if (wr_lo) begin
            st_d.cnt = {st_q.hbuf, bus_wdata_i};
        end else if (inc) begin
            st_d.cnt = cnt_sum[CNT_W-1:0];
            roll     = cnt_sum[CNT_W];
        end

        if (roll) begin
            st_d.ovf = 1'b1;
        end else if (wr_ctrl && !bus_wdata_i[FLAG_BIT]) begin
            st_d.ovf = 1'b0;
        end

        if (wr_hbuf) begin
            st_d.hbuf = bus_wdata_i;
        end else if (rd_lo) begin
            st_d.hbuf = st_q.cnt[CNT_W-1:BUS_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr_i)
            SEL_CTRL: bus_rdata_o = {st_q.ovf, {PAD_W{1'b0}}, st_q.ctrl};
            SEL_LO:   bus_rdata_o = st_q.cnt[BUS_W-1:0];
            SEL_HBUF: bus_rdata_o = st_q.hbuf;
            default:  bus_rdata_o = '0;
        endcase
    end

    assign ovf_flag_o = st_q.ovf;
    assign cnt_now    = st_q.cnt;
    assign hbuf_now   = st_q.hbuf;
    assign run_now    = st_q.ctrl.run;
endmodule

// File: rtl/tmr16_checker.sv
`timescale 1ns/1ps
module tmr16_checker #(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trig_clr_i,
    input logic               bus_wr_i,
    input logic               bus_rd_i,
    input logic [1:0]         bus_addr_i,
    input logic [7:0]         bus_wdata_i,
    input logic               ovf_flag_o,
    input logic [CNT_W-1:0]   cnt_now,
    input logic [CNT_W/2-1:0] hbuf_now,
    input logic               run_now
);
    localparam int BUS_W = CNT_W / 2;

    logic wr_lo_c, rd_lo_c, clr_c;
    assign wr_lo_c = bus_wr_i && (bus_addr_i == 2'd1);
    assign rd_lo_c = bus_rd_i && (bus_addr_i == 2'd1);
    assign clr_c   = bus_wr_i && (bus_addr_i == 2'd0) && !bus_wdata_i[7];

    a_r11_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
        trig_clr_i |=> (cnt_now == '0));

    a_r10_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_c && !trig_clr_i) |=> (cnt_now == {$past(hbuf_now), $past(bus_wdata_i)}));

    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_now && !trig_clr_i && !wr_lo_c) |=> $stable(cnt_now));

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_clr_i && !wr_lo_c) |=> ((cnt_now == $past(cnt_now)) ||
                                       (cnt_now == $past(cnt_now) + 1'b1)));

    a_r7_roll_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_now == '1) && !trig_clr_i && !wr_lo_c) |=> ((cnt_now != '0) || ovf_flag_o));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_o && !clr_c) |=> ovf_flag_o);

    a_r9_hbuf_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo_c && !bus_wr_i) |=> (hbuf_now == $past(cnt_now[CNT_W-1:BUS_W])));
endmodule

bind tmr16_prescaled tmr16_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_clr_i  (trig_clr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .ovf_flag_o  (ovf_flag_o),
    .cnt_now     (cnt_now),
    .hbuf_now    (hbuf_now),
    .run_now     (run_now)
);

// File: tb/tmr16_prescaled_tb.sv
`timescale 1ns/1ps
module tmr16_prescaled_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_i = 1'b0;
    logic       trig = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] addr = 2'd1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int    n_chk = 0;
    int    n_err = 0;
    bit    ext_free = 1'b0;
    bit    done = 1'b0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    tmr16_prescaled u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clk_i   (ext_i),
        .trig_clr_i  (trig),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .ovf_flag_o  (irq)
    );

    // Free-running external clock on whole-ns times; clock edges fall on half-ns
    initial forever begin
        if (ext_free) begin
            #7 ext_i = ~ext_i;
        end else begin
            #1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_pre, m_cyc, m_ctrl, m_flag, m_buf, m_old, m_lim;
    bit p1, p2, p3, m_raw, m_inc, m_roll;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_cyc = 0; m_ctrl = 0; m_flag = 0; m_buf = 0;
            p1 = 0; p2 = 0; p3 = 0;
        end else begin
            m_old = m_cnt;
            if (m_ctrl[1]) m_raw = m_ctrl[2] ? (p1 && !p2) : (p2 && !p3);
            else           m_raw = ((m_cyc % 4) == 3);
            m_lim = (1 << ((m_ctrl >> 3) & 3)) - 1;
            m_inc = 0;
            if (wr && addr == 2'd1) m_pre = 0;
            else if (m_ctrl[0] && m_raw) begin
                if (m_pre >= m_lim) begin m_pre = 0; m_inc = 1; end
                else m_pre = m_pre + 1;
            end
            m_roll = 0;
            if (trig) m_cnt = 0;
            else if (wr && addr == 2'd1) m_cnt = m_buf * 256 + int'(wdata);
            else if (m_inc) begin
                if (m_cnt == 65535) begin m_cnt = 0; m_roll = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (m_roll) m_flag = 1;
            else if (wr && addr == 2'd0 && !wdata[7]) m_flag = 0;
            if (wr && addr == 2'd0) m_ctrl = int'(wdata) & 8'h1f;
            if (wr && addr == 2'd2) m_buf = int'(wdata);
            else if (rd && addr == 2'd1) m_buf = m_old / 256;
            p3 = p2; p2 = p1; p1 = ext_i;
            m_cyc = m_cyc + 1;
        end
    end

    // Per-cycle comparison, away from the active edge
    int m_exp;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            case (addr)
                2'd0: m_exp = (m_flag << 7) | m_ctrl;
                2'd1: m_exp = m_cnt % 256;
                2'd2: m_exp = m_buf;
                default: m_exp = 0;
            endcase
            chk({phase, " model rdata"}, int'(rdata), m_exp);
            chk({phase, " model flag"}, int'(irq), m_flag);
        end
    end

    // ---------------- stimulus helpers (start at posedge+1) ----------------
    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0; addr = 2'd1;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        addr = a; rd = 1'b1;
        @(negedge clk); v = rdata;
        @(posedge clk); #1;
        rd = 1'b0; addr = 2'd1;
    endtask

    task automatic peek(input string tag, input int exp);
        @(negedge clk); chk(tag, int'(rdata), exp);
        @(posedge clk); #1;
    endtask

    logic [7:0] v, v2;

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        phase = "R1";
        rd_reg(2'd0, v); chk("R1 ctrl", int'(v), 0);
        rd_reg(2'd1, v); chk("R1 low", int'(v), 0);
        rd_reg(2'd2, v); chk("R1 hbuf", int'(v), 0);
        chk("R1 flag pin", int'(irq), 0);

        // R9 / R10 buffered access
        phase = "R9";
        wr_reg(2'd2, 8'h12);
        phase = "R10";
        wr_reg(2'd1, 8'h34);
        rd_reg(2'd1, v); chk("R10 low after load", int'(v), 8'h34);
        rd_reg(2'd2, v); chk("R9 hbuf after low read", int'(v), 8'h12);
        phase = "R9";
        wr_reg(2'd2, 8'h77);
        rd_reg(2'd2, v); chk("R9 hbuf write", int'(v), 8'h77);
        rd_reg(2'd1, v); chk("R9 low unchanged by hbuf write", int'(v), 8'h34);
        rd_reg(2'd2, v); chk("R9 hbuf relatched", int'(v), 8'h12);

        // R3 internal tick, divide 1
        phase = "R3";
        wr_reg(2'd0, 8'h01);
        idle(120);

        // R4 divide codes
        phase = "R4";
        for (int c = 1; c < 4; c++) begin
            wr_reg(2'd0, 8'((c << 3) | 1));
            idle(150);
        end
        wr_reg(2'd1, 8'h00);
        idle(100);

        // R2 hold while off
        phase = "R2";
        wr_reg(2'd0, 8'h18);
        rd_reg(2'd1, v);
        idle(50);
        rd_reg(2'd1, v2);
        chk("R2 held low byte", int'(v2), int'(v));

        // R7 / R8 rollover meets clearing write in the same cycle
        phase = "R8";
        wr_reg(2'd2, 8'hFF);
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd0, 8'h07);
        idle(4);
        ext_i = 1'b1;          // sampled at edge 1, counts at edge 2
        idle(1);
        wr_reg(2'd0, 8'h07);   // clearing write held over edge 2
        chk("R8 rollover wins over clear", int'(irq), 1);
        phase = "R7";
        peek("R7 wrapped to zero", 0);
        chk("R7 flag pin set", int'(irq), 1);
        phase = "R8";
        wr_reg(2'd0, 8'h87);
        chk("R8 write of one keeps flag", int'(irq), 1);
        wr_reg(2'd0, 8'h07);
        chk("R8 write of zero clears flag", int'(irq), 0);
        ext_i = 1'b0;
        idle(4);

        // R5 synchronized latency
        phase = "R5";
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd1, 8'h10);
        wr_reg(2'd0, 8'h03);
        idle(4);
        ext_i = 1'b1;
        idle(2);
        peek("R5 not yet counted", 8'h10);
        peek("R5 counted two edges after sampling", 8'h11);
        ext_i = 1'b0;
        idle(4);

        // R6 bypass latency
        phase = "R6";
        wr_reg(2'd1, 8'h10);
        wr_reg(2'd0, 8'h07);
        idle(4);
        ext_i = 1'b1;
        idle(1);
        peek("R6 not yet counted", 8'h10);
        peek("R6 counted one edge after sampling", 8'h11);
        ext_i = 1'b0;
        idle(4);

        // R11 clear pulse alone, against an increment, against a load
        phase = "R11";
        wr_reg(2'd1, 8'h40);
        idle(2);
        ext_i = 1'b1;
        idle(1);
        trig = 1'b1;           // held over the increment edge
        idle(1);
        trig = 1'b0;
        peek("R11 clear beats increment", 0);
        ext_i = 1'b0;
        idle(4);
        wr_reg(2'd1, 8'h55);
        trig = 1'b1;
        wr_reg(2'd1, 8'h66);
        trig = 1'b0;
        peek("R11 clear beats load", 0);

        // Free-running asynchronous external clock, both paths
        phase = "R5";
        wr_reg(2'd0, 8'h03);
        ext_free = 1'b1;
        idle(300);
        phase = "R6";
        wr_reg(2'd0, 8'h07);
        idle(300);
        phase = "R4";
        wr_reg(2'd0, 8'h13);
        idle(300);
        ext_free = 1'b0;
        idle(10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule